// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and a calendar as eight packed-BCD byte fields: hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year. A one-cycle pulse on `tick_100hz` arrives every hundredth of a second. Each pulse moves the whole carry chain forward on a single clock edge, so all fields change together and always agree with each other. The hours field has a format bit that picks a 12-hour or a 24-hour count. At month end the date wraps according to the month's length, and February has 29 days in years divisible by four.

Software presets the fields through a load port. One field is written per cycle, and the field is chosen by a 3-bit select code. Bit 7 of the month field is an active-high oscillator stop, and it is set at reset. A two-state controller follows that bit. In state ST_HALTED every tick is ignored. In state ST_RUNNING ticks are counted. The transition "start" (ST_HALTED to ST_RUNNING) is taken on the clock edge after the stop bit reads 0. The transition "stop" (ST_RUNNING to ST_HALTED) is taken on the clock edge after the stop bit reads 1.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read: hundredths 00, seconds 00, minutes 00, hours 00 (24-hour), day of week 01, date 01, month 81 (stop bit set, month 1), year 00.
- R2: In ST_RUNNING, each tick advances hundredths through BCD 00..99. Its wrap advances seconds 00..59, which in turn advance minutes 00..59, which in turn advance hours. All of these change on the same edge.
- R3: With hours bit 6 = 0 (24-hour), bits 5:0 count BCD 00..23, and bit 5 is the tens digit for hours 20 to 23. The step from 23 to 00 advances the day of week and the date.
- R4: With hours bit 6 = 1 (12-hour), bits 4:0 count BCD 12, 01..11, and bit 5 is the PM flag (1 = PM). The PM flag toggles on the step from 11 to 12. The date and day of week advance only on the step from 11 PM to 12 AM.
- R5: The day of week counts 01..07 and returns to 01 on the day change after 07.
- R6: The date returns to 01 after the last day of the month. April, June, September and November have 30 days; February has 28 days, or 29 when the BCD year 00..99 is divisible by 4; all other months have 31. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: While month bit 7 is 1, no field advances on a tick. After a load clears that bit, a tick is counted only when it is sampled at the second clock edge after the load edge or later.
- R8: When `ld_en` is high, `ld_data` is written on the next edge into the field named by `ld_sel`: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. All other fields are held, and a tick in the same cycle is dropped.
- R9: Unused bits read 0 whatever is loaded: bit 7 of seconds, minutes and hours; bits 7:3 of day of week; bits 7:6 of date; bits 6:5 of month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse every 0.01 s |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field select for the load |
| ld_data | input | 8 | Value to load |
| hsec | output | 8 | Hundredths of a second, BCD |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours with format and PM/20-hour bits |
| wday | output | 8 | Day of week 1..7 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month in BCD, bit 7 stops the clock |
| year | output | 8 | Year 00..99, BCD |

## Verification
The bench builds the block with its default parameters, which match the field layout and the reset stop bit given above. Because a single load can place the chain just before any rollover, the bench can sweep exhaustively rather than wait for time to pass. It sweeps every hundredth and every second, every hour in both formats, and every day-of-week value. It also sweeps the month-end rollover of all 1200 month-and-year pairs, plus the February 28 case of every year, which separates leap years from common years.

// File: rtl/rtcc_pkg.sv
`timescale 1ns/1ps
package rtcc_pkg;
    localparam int FW = 8;
    typedef logic [FW-1:0] bcd8_t;

    typedef enum logic [2:0] {
        SEL_HSEC = 3'd0,
        SEL_SEC  = 3'd1,
        SEL_MIN  = 3'd2,
        SEL_HOUR = 3'd3,
        SEL_WDAY = 3'd4,
        SEL_DATE = 3'd5,
        SEL_MON  = 3'd6,
        SEL_YEAR = 3'd7
    } fsel_t;

    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;

    // next BCD value of a two-digit number; the caller handles the top wrap
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic leap_year(input bcd8_t y);
        logic [7:0] b;
        b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
        return (b[1:0] == 2'b00);
    endfunction

    function automatic bcd8_t month_len(input bcd8_t m, input logic leap);
        bcd8_t r;
        case (m)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtcc_wrap_counter.sv
`timescale 1ns/1ps
module rtcc_wrap_counter
    import rtcc_pkg::*;
#(
    parameter bcd8_t LO   = 8'h00,
    parameter bcd8_t HI   = 8'h59,
    parameter bcd8_t MASK = 8'h7F,
    parameter bcd8_t RST  = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  bcd8_t ld_val,
    input  logic  step,
    output bcd8_t val_q,
    output logic  carry
);
    localparam bcd8_t SPAN = HI - LO;

    bcd8_t nxt;
    logic  at_top;

    always_comb begin
        at_top = (val_q >= HI);
        carry  = step && at_top;
        if (ld)        nxt = ld_val & MASK;
        else if (step) nxt = at_top ? LO : (bcd_inc(val_q) & MASK);
        else           nxt = val_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= RST;
        else        val_q <= nxt;
    end

    bcd8_t off;
    assign off = val_q - LO;

    // a counter inside its range stays inside it after a step
    assert_wrap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && off <= SPAN) |=> ((val_q - LO) <= SPAN));
endmodule

// File: rtl/rtcc_hours.sv
`timescale 1ns/1ps
module rtcc_hours
    import rtcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  bcd8_t ld_val,
    input  logic  step,
    output bcd8_t hour_q,
    output logic  carry
);
    localparam bcd8_t HOUR_MASK = 8'h7F;
    localparam bcd8_t H24_MASK  = 8'h3F;

    bcd8_t nxt;
    bcd8_t inc12;
    bcd8_t inc24;

    always_comb begin
        inc12 = bcd_inc({3'b000, hour_q[4:0]});
        inc24 = bcd_inc({2'b00, hour_q[5:0]}) & H24_MASK;
        nxt   = hour_q;
        carry = 1'b0;
        if (ld) begin
            nxt = ld_val & HOUR_MASK;
        end else if (step) begin
            if (!hour_q[6]) begin
                if (hour_q[5:0] >= 6'h23) begin
                    nxt   = 8'h00;
                    carry = 1'b1;
                end else begin
                    nxt = inc24;
                end
            end else begin
                if (hour_q[4:0] == 5'h11) begin
                    nxt   = {2'b01, ~hour_q[5], 5'h12};
                    carry = hour_q[5];
                end else if (hour_q[4:0] >= 5'h12) begin
                    nxt = {2'b01, hour_q[5], 5'h01};
                end else begin
                    nxt = {2'b01, hour_q[5], inc12[4:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hour_q <= 8'h00;
        else        hour_q <= nxt;
    end

    assert_pm_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && hour_q[6] && hour_q[4:0] == 5'h11)
        |=> (hour_q[5] != $past(hour_q[5]) && hour_q[4:0] == 5'h12));

    assert_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !hour_q[6] && hour_q[5:0] == 6'h23) |=> (hour_q == 8'h00));
endmodule

// File: rtl/rtcc_calendar.sv
`timescale 1ns/1ps
module rtcc_calendar
    import rtcc_pkg::*;
#(
    parameter logic OSC_OFF_RST = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_date,
    input  logic  ld_mon,
    input  bcd8_t ld_val,
    input  logic  step,
    input  bcd8_t year_q,
    output bcd8_t date_q,
    output bcd8_t mon_reg,
    output logic  carry
);
    localparam bcd8_t DATE_MASK = 8'h3F;

    logic [4:0] mon_q;
    logic       osc_off_q;
    logic [4:0] mon_nxt;
    logic       osc_nxt;
    bcd8_t      date_nxt;
    bcd8_t      last_day;
    bcd8_t      mon_inc;
    logic       date_end;
    logic       mon_end;

    always_comb begin
        last_day = month_len({3'b000, mon_q}, leap_year(year_q));
        mon_inc  = bcd_inc({3'b000, mon_q});
        date_end = (date_q >= last_day);
        mon_end  = (mon_q >= 5'h12);
        carry    = step && date_end && mon_end;

        if (ld_date)   date_nxt = ld_val & DATE_MASK;
        else if (step) date_nxt = date_end ? 8'h01 : (bcd_inc(date_q) & DATE_MASK);
        else           date_nxt = date_q;

        if (ld_mon)                mon_nxt = ld_val[4:0];
        else if (step && date_end) mon_nxt = mon_end ? 5'h01 : mon_inc[4:0];
        else                       mon_nxt = mon_q;

        osc_nxt = ld_mon ? ld_val[7] : osc_off_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q    <= 8'h01;
            mon_q     <= 5'h01;
            osc_off_q <= OSC_OFF_RST;
        end else begin
            date_q    <= date_nxt;
            mon_q     <= mon_nxt;
            osc_off_q <= osc_nxt;
        end
    end

    assign mon_reg = {osc_off_q, 2'b00, mon_q};

    assert_date_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_date && !ld_mon && date_q >= 8'h01 && date_q <= 8'h31)
        |=> (date_q >= 8'h01 && date_q <= 8'h31));

    assert_new_year_R6: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (mon_q == 5'h01 && date_q == 8'h01));
endmodule

// File: rtl/bcd_calendar_core.sv
`timescale 1ns/1ps
module bcd_calendar_core
    import rtcc_pkg::*;
#(
    parameter logic OSC_OFF_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_100hz,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [7:0] ld_data,
    output logic [7:0] hsec,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic [7:0] wday,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year
);
    localparam int NFIELD = 8;

    run_state_t state_q;
    run_state_t state_d;
    logic       step_hs;
    logic [NFIELD-1:0] ld_vec;
    logic c_hs, c_s, c_m, c_h, c_d, c_y;

    // one load strobe per field
    for (genvar i = 0; i < NFIELD; i++) begin : g_ld
        assign ld_vec[i] = ld_en && (ld_sel == 3'(i));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OSC_OFF_RST ? ST_HALTED : ST_RUNNING;
        else        state_q <= state_d;
    end

    // next state and step output
    always_comb begin
        state_d = state_q;
        step_hs = 1'b0;
        unique case (state_q)
            ST_HALTED: begin
                if (!month[7]) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                step_hs = tick_100hz && !ld_en;
                if (month[7]) state_d = ST_HALTED;
            end
            default: state_d = ST_HALTED;
        endcase
    end

    rtcc_wrap_counter #(.LO(8'h00), .HI(8'h99), .MASK(8'hFF), .RST(8'h00)) u_hsec (
        .clk(clk), .rst_n(rst_n), .ld(ld_vec[SEL_HSEC]), .ld_val(ld_data),
        .step(step_hs), .val_q(hsec), .carry(c_hs));

    rtcc_wrap_counter #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F), .RST(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .ld(ld_vec[SEL_SEC]), .ld_val(ld_data),
        .step(c_hs), .val_q(sec), .carry(c_s));

    rtcc_wrap_counter #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F), .RST(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .ld(ld_vec[SEL_MIN]), .ld_val(ld_data),
        .step(c_s), .val_q(min), .carry(c_m));

    rtcc_hours u_hour (
        .clk(clk), .rst_n(rst_n), .ld(ld_vec[SEL_HOUR]), .ld_val(ld_data),
        .step(c_m), .hour_q(hour), .carry(c_h));

    rtcc_wrap_counter #(.LO(8'h01), .HI(8'h07), .MASK(8'h07), .RST(8'h01)) u_wday (
        .clk(clk), .rst_n(rst_n), .ld(ld_vec[SEL_WDAY]), .ld_val(ld_data),
        .step(c_h), .val_q(wday), .carry(c_d));

    rtcc_calendar #(.OSC_OFF_RST(OSC_OFF_RST)) u_cal (
        .clk(clk), .rst_n(rst_n), .ld_date(ld_vec[SEL_DATE]), .ld_mon(ld_vec[SEL_MON]),
        .ld_val(ld_data), .step(c_h), .year_q(year), .date_q(date),
        .mon_reg(month), .carry(c_y));

    logic c_yy;
    rtcc_wrap_counter #(.LO(8'h00), .HI(8'h99), .MASK(8'hFF), .RST(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .ld(ld_vec[SEL_YEAR]), .ld_val(ld_data),
        .step(c_y), .val_q(year), .carry(c_yy));

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED && !ld_en) |=> $stable(hsec));

    assert_load_hsec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_sel == 3'(SEL_HSEC)) |=> (hsec == $past(ld_data)));

    assert_load_holds_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_sel != 3'(SEL_SEC)) |=> $stable(sec));

    assert_year_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_yy |=> (year == 8'h00));

    assert_wday_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_d && !ld_en) |=> (wday == 8'h01));
endmodule

// File: tb/sim_bcd_calendar_core.sv
`timescale 1ns/1ps
module sim_bcd_calendar_core;
    import rtcc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] hsec, sec, min, hour, wday, date, month, year;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bcd_calendar_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_data(ld_data), .hsec(hsec), .sec(sec), .min(min),
        .hour(hour), .wday(wday), .date(date), .month(month), .year(year));

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] h12(input int h);
        int d;
        d = (h % 12 == 0) ? 12 : h % 12;
        return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(d);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] s, input logic [7:0] d, input logic with_tick);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_data = d; tick = with_tick;
        @(negedge clk);
        ld_en = 1'b0; tick = 1'b0;
    endtask

    task automatic step1;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic day_end(input logic [7:0] hr);
        load(SEL_HSEC, 8'h99, 1'b0);
        load(SEL_SEC, 8'h59, 1'b0);
        load(SEL_MIN, 8'h59, 1'b0);
        load(SEL_HOUR, hr, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hsec", hsec, 8'h00);
        chk("R1 sec", sec, 8'h00);
        chk("R1 min", min, 8'h00);
        chk("R1 hour", hour, 8'h00);
        chk("R1 wday", wday, 8'h01);
        chk("R1 date", date, 8'h01);
        chk("R1 month", month, 8'h81);
        chk("R1 year", year, 8'h00);

        // R7: halted after reset
        repeat (3) step1();
        chk("R7 halted hsec", hsec, 8'h00);

        // R9: unused bits masked
        load(SEL_SEC, 8'hFF, 1'b0);  chk("R9 sec", sec, 8'h7F);
        load(SEL_MIN, 8'hFF, 1'b0);  chk("R9 min", min, 8'h7F);
        load(SEL_HOUR, 8'hFF, 1'b0); chk("R9 hour", hour, 8'h7F);
        load(SEL_WDAY, 8'hFF, 1'b0); chk("R9 wday", wday, 8'h07);
        load(SEL_DATE, 8'hFF, 1'b0); chk("R9 date", date, 8'h3F);
        load(SEL_MON, 8'hFF, 1'b0);  chk("R9 month", month, 8'h9F);
        load(SEL_HSEC, 8'hFF, 1'b0); chk("R8 hsec full", hsec, 8'hFF);

        // R7: start latency
        load(SEL_HSEC, 8'h00, 1'b0);
        load(SEL_SEC, 8'h00, 1'b0);
        load(SEL_MIN, 8'h00, 1'b0);
        load(SEL_HOUR, 8'h00, 1'b0);
        load(SEL_MON, 8'h01, 1'b0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R7 early tick dropped", hsec, 8'h00);
        step1();
        chk("R7 running", hsec, 8'h01);

        // R2: hundredths sweep into seconds
        load(SEL_HSEC, 8'h00, 1'b0);
        for (int i = 1; i < 200; i++) begin
            step1();
            chk("R2 hsec", hsec, bcd(i % 100));
            chk("R2 sec", sec, bcd(i / 100));
        end

        // R2: seconds sweep into minutes
        for (int s = 0; s < 60; s++) begin
            load(SEL_MIN, 8'h10, 1'b0);
            load(SEL_SEC, bcd(s), 1'b0);
            load(SEL_HSEC, 8'h99, 1'b0);
            step1();
            chk("R2 sec step", sec, bcd((s + 1) % 60));
            chk("R2 min step", min, (s == 59) ? 8'h11 : 8'h10);
            chk("R2 hsec wrap", hsec, 8'h00);
        end

        // R3: 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            load(SEL_DATE, 8'h05, 1'b0);
            load(SEL_WDAY, 8'h02, 1'b0);
            load(SEL_YEAR, 8'h21, 1'b0);
            load(SEL_MON, 8'h03, 1'b0);
            day_end(bcd(h));
            step1();
            chk("R3 hour", hour, bcd((h + 1) % 24));
            chk("R3 min", min, 8'h00);
            chk("R3 date", date, (h == 23) ? 8'h06 : 8'h05);
            chk("R3 wday", wday, (h == 23) ? 8'h03 : 8'h02);
        end

        // R4: 12-hour sweep
        for (int h = 0; h < 24; h++) begin
            load(SEL_DATE, 8'h05, 1'b0);
            load(SEL_WDAY, 8'h02, 1'b0);
            day_end(h12(h));
            step1();
            chk("R4 hour", hour, h12((h + 1) % 24));
            chk("R4 date", date, (h == 23) ? 8'h06 : 8'h05);
            chk("R4 wday", wday, (h == 23) ? 8'h03 : 8'h02);
        end

        // R5: day of week
        for (int w = 1; w <= 7; w++) begin
            load(SEL_DATE, 8'h10, 1'b0);
            load(SEL_WDAY, bcd(w), 1'b0);
            day_end(8'h23);
            step1();
            chk("R5 wday", wday, (w == 7) ? 8'h01 : bcd(w + 1));
        end

        // R6: month ends over every month of every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                load(SEL_YEAR, bcd(y), 1'b0);
                load(SEL_MON, bcd(m), 1'b0);
                load(SEL_DATE, bcd(mlen(m, y)), 1'b0);
                load(SEL_WDAY, 8'h07, 1'b0);
                day_end(8'h23);
                step1();
                chk("R6 date", date, 8'h01);
                chk("R6 month", month, (m == 12) ? 8'h01 : bcd(m + 1));
                chk("R6 year", year, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
                chk("R5 wday wrap", wday, 8'h01);
                if (m == 2) begin
                    load(SEL_MON, 8'h02, 1'b0);
                    load(SEL_YEAR, bcd(y), 1'b0);
                    load(SEL_DATE, 8'h28, 1'b0);
                    day_end(8'h23);
                    step1();
                    chk("R6 feb28 date", date, (y % 4 == 0) ? 8'h29 : 8'h01);
                    chk("R6 feb28 month", month, (y % 4 == 0) ? 8'h02 : 8'h03);
                end
            end
        end

        // R8: load with a tick in the same cycle
        load(SEL_MIN, 8'h21, 1'b0);
        load(SEL_HSEC, 8'h40, 1'b0);
        load(SEL_SEC, 8'h33, 1'b1);
        chk("R8 loaded sec", sec, 8'h33);
        chk("R8 hsec held", hsec, 8'h40);
        chk("R8 min held", min, 8'h21);
        step1();
        chk("R8 next tick counts", hsec, 8'h41);

        // R7: stop again
        load(SEL_MON, 8'h85, 1'b0);
        step1();
        step1();
        chk("R7 stopped hsec", hsec, 8'h41);
        chk("R7 month readback", month, 8'h85);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule